// File: doc/BRIEF.md
# Memory Ordering Issue Gate

This block sits between a front end that delivers memory micro-operations strictly in program order and a memory port that may complete them in any order. It holds the pending operations in a small window. Each cycle it offers the memory port the oldest operation that may legally go ahead of the older operations that are still incomplete. A run-time model select sets which pairs of loads and stores may be reordered: sequential, total store ordering, partial store ordering or weak ordering.

Fences carry no address. A fence orders operations by their position in the stream and by their type. It never reaches the memory port: it completes inside the window once the older operations it waits on have been acknowledged. An atomic read-modify-write is a memory access and also a full barrier. Completion acknowledgements come back with the operation's tag, in any order. Entries leave the window from the oldest end once they are complete.

Top module: `mo_issue_gate`

## Requirements
- R1: After reset the window is empty, `in_ready` is 1 and `iss_valid` is 0.
- R2: Sequential model (`model_sel`=0): no load or store is offered while any older load or store has not been acknowledged.
- R3: Total store ordering (`model_sel`=1): a load may be offered ahead of an older unacknowledged store. A store waits for every older load and store, and a load waits for every older load.
- R4: Partial store ordering (`model_sel`=2): a load or a store may be offered ahead of older unacknowledged stores. Nothing passes an older unacknowledged load.
- R5: Weak ordering (`model_sel`=3): loads and stores pass each other freely. Only fences and atomics impose order.
- R6: A full fence (`in_kind`=2, `in_fence`=0 or 3) completes only once every older entry is complete. No younger operation is offered before that. A fence is never offered on the issue port.
- R7: A load fence (`in_fence`=1) waits for older loads and atomics and holds back younger loads and atomics. Stores pass it.
- R8: A store fence (`in_fence`=2) waits for older stores and atomics and holds back younger stores and atomics. Loads pass it.
- R9: An atomic (`in_kind`=3) is offered only when every older entry is complete. No younger operation is offered until the atomic has been acknowledged.
- R10: When several operations are legal, the oldest one is offered. At most one is issued per cycle, on `iss_valid` and `iss_ready` both high.
- R11: With DEPTH entries held, `in_ready` is 0. An entry is freed only from the oldest end, so an acknowledgement of a younger entry alone does not raise `in_ready`.
- R12: A new `model_sel` value is applied only on a cycle when the window is empty. A change while entries are pending has no effect on them.

Operation codes on `in_kind`/`iss_kind`: 0 load, 1 store, 2 fence, 3 atomic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| model_sel | input | 2 | Consistency model: 0 sequential, 1 TSO, 2 PSO, 3 weak |
| in_valid | input | 1 | Enqueue request |
| in_ready | output | 1 | Window has a free entry |
| in_kind | input | 2 | Operation code |
| in_fence | input | 2 | Fence kind: 0/3 full, 1 load, 2 store |
| in_tag | input | TAG_W | Tag of the operation |
| iss_valid | output | 1 | An operation is offered to the memory port |
| iss_ready | input | 1 | Memory port accepts the offered operation |
| iss_kind | output | 2 | Operation code of the offered operation |
| iss_tag | output | TAG_W | Tag of the offered operation |
| ack_valid | input | 1 | Completion acknowledgement |
| ack_tag | input | TAG_W | Tag being acknowledged |

## Verification
The assertions assume that tags are unique among the operations in the window. They also assume that an acknowledgement only names an operation that has already been issued. The stimulus gives every live operation a distinct tag and acknowledges only tags it has seen on the issue port. Stray acknowledgements sent while draining carry tags with no issued entry, and the design must ignore them. Model changes are made only after a drain, except in the test that checks a change is ignored while entries are pending.

// File: rtl/mo_gate_pkg.sv
package mo_gate_pkg;

  typedef enum logic [1:0] {
    OP_LD    = 2'd0,
    OP_ST    = 2'd1,
    OP_FENCE = 2'd2,
    OP_AMO   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FN_ALL  = 2'd0,
    FN_LD   = 2'd1,
    FN_ST   = 2'd2,
    FN_ALL2 = 2'd3
  } fence_e;

  typedef enum logic [1:0] {
    M_SEQ  = 2'd0,
    M_TSO  = 2'd1,
    M_PSO  = 2'd2,
    M_WEAK = 2'd3
  } model_e;

  typedef struct packed {
    logic   vld;
    op_e    kind;
    fence_e fk;
    logic   issued;
    logic   done;
  } slot_t;

  function automatic logic reads(op_e k);
    return (k == OP_LD) || (k == OP_AMO);
  endfunction

  function automatic logic writes(op_e k);
    return (k == OP_ST) || (k == OP_AMO);
  endfunction

  // Older incomplete entry of kind ok (fence kind ofk) holds back younger access yk
  function automatic logic holds_back(model_e m, op_e ok, fence_e ofk, op_e yk);
    logic r;
    if (ok == OP_FENCE) begin
      case (ofk)
        FN_LD:   r = reads(yk);
        FN_ST:   r = writes(yk);
        default: r = 1'b1;
      endcase
    end else if (ok == OP_AMO || yk == OP_AMO) begin
      r = 1'b1;
    end else begin
      case (m)
        M_SEQ:   r = 1'b1;
        M_TSO:   r = !(ok == OP_ST && yk == OP_LD);
        M_PSO:   r = (ok == OP_LD);
        default: r = 1'b0;
      endcase
    end
    return r;
  endfunction

  // A fence of kind fk must wait for an older incomplete entry of kind ok
  function automatic logic fence_waits(fence_e fk, op_e ok);
    logic r;
    case (fk)
      FN_LD:   r = reads(ok);
      FN_ST:   r = writes(ok);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mo_order_rules.sv
module mo_order_rules
  import mo_gate_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  slot_t [DEPTH-1:0] slots,
  input  logic [PTR_W-1:0]  head,
  input  model_e            model,
  output logic [DEPTH-1:0]  legal,
  output logic [DEPTH-1:0]  fence_ok
);

  logic [PTR_W-1:0] age [DEPTH];

  always_comb begin
    for (int a = 0; a < DEPTH; a++) begin
      age[a] = PTR_W'(a) - head;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic blk;
    logic fblk;
    always_comb begin
      blk  = 1'b0;
      fblk = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && slots[j].vld && !slots[j].done && age[j] < age[i]) begin
          blk  = blk  | holds_back(model, slots[j].kind, slots[j].fk, slots[i].kind);
          fblk = fblk | fence_waits(slots[i].fk, slots[j].kind);
        end
      end
      legal[i]    = slots[i].vld && !slots[i].issued && !slots[i].done &&
                    (slots[i].kind != OP_FENCE) && !blk;
      fence_ok[i] = slots[i].vld && !slots[i].done &&
                    (slots[i].kind == OP_FENCE) && !fblk;
    end
  end

endmodule

// File: rtl/mo_oldest_pick.sv
module mo_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [PTR_W-1:0] head,
  output logic             found,
  output logic [PTR_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (req[head + PTR_W'(k)]) begin
        found = 1'b1;
        idx   = head + PTR_W'(k);
      end
    end
  end

endmodule

// File: rtl/mo_slot_window.sv
module mo_slot_window
  import mo_gate_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enq,
  input  op_e                         enq_kind,
  input  fence_e                      enq_fk,
  input  logic [TAG_W-1:0]            enq_tag,
  input  logic                        iss_fire,
  input  logic [PTR_W-1:0]            iss_idx,
  input  logic                        ack_valid,
  input  logic [TAG_W-1:0]            ack_tag,
  input  logic [DEPTH-1:0]            fence_set,
  output slot_t [DEPTH-1:0]           slots,
  output logic [DEPTH-1:0][TAG_W-1:0] tags,
  output logic [PTR_W-1:0]            head,
  output logic [CNT_W-1:0]            count
);

  slot_t [DEPTH-1:0]           slots_q;
  logic [DEPTH-1:0][TAG_W-1:0] tags_q;
  logic [PTR_W-1:0]            head_q, tail_q;
  logic [CNT_W-1:0]            count_q;
  logic [DEPTH-1:0]            ack_hit;
  logic                        retire;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cam
    assign ack_hit[i] = ack_valid && slots_q[i].vld && slots_q[i].issued &&
                        !slots_q[i].done && (slots_q[i].kind != OP_FENCE) &&
                        (tags_q[i] == ack_tag);
  end

  assign retire = slots_q[head_q].vld && slots_q[head_q].done;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fence_set[i] || ack_hit[i]) slots_q[i].done <= 1'b1;
        if (iss_fire && iss_idx == PTR_W'(i)) slots_q[i].issued <= 1'b1;
      end
      if (retire) begin
        slots_q[head_q] <= '0;
        head_q          <= head_q + 1'b1;
      end
      if (enq) begin
        slots_q[tail_q] <= '{vld: 1'b1, kind: enq_kind, fk: enq_fk,
                             issued: 1'b0, done: 1'b0};
        tail_q          <= tail_q + 1'b1;
      end
      count_q <= count_q + CNT_W'(enq) - CNT_W'(retire);
    end
  end

  always_ff @(posedge clk) begin
    if (enq) tags_q[tail_q] <= enq_tag;
  end

  assign slots = slots_q;
  assign tags  = tags_q;
  assign head  = head_q;
  assign count = count_q;

endmodule

// File: rtl/mo_issue_gate.sv
module mo_issue_gate
  import mo_gate_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       model_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [1:0]       in_fence,
  input  logic [TAG_W-1:0] in_tag,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [1:0]       iss_kind,
  output logic [TAG_W-1:0] iss_tag,
  input  logic             ack_valid,
  input  logic [TAG_W-1:0] ack_tag
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  slot_t [DEPTH-1:0]           slots;
  logic [DEPTH-1:0][TAG_W-1:0] tags;
  logic [PTR_W-1:0]            head;
  logic [CNT_W-1:0]            count;
  logic [DEPTH-1:0]            legal, fence_ok;
  logic                        found;
  logic [PTR_W-1:0]            pick;
  model_e                      model_q;
  logic                        enq;

  always_ff @(posedge clk) begin
    if (rst)               model_q <= M_SEQ;
    else if (count == '0)  model_q <= model_e'(model_sel);
  end

  assign in_ready = (count != CNT_W'(DEPTH));
  assign enq      = in_valid && in_ready;

  mo_slot_window #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .enq       (enq),
    .enq_kind  (op_e'(in_kind)),
    .enq_fk    (fence_e'(in_fence)),
    .enq_tag   (in_tag),
    .iss_fire  (iss_valid && iss_ready),
    .iss_idx   (pick),
    .ack_valid (ack_valid),
    .ack_tag   (ack_tag),
    .fence_set (fence_ok),
    .slots     (slots),
    .tags      (tags),
    .head      (head),
    .count     (count)
  );

  mo_order_rules #(.DEPTH(DEPTH)) u_rules (
    .slots    (slots),
    .head     (head),
    .model    (model_q),
    .legal    (legal),
    .fence_ok (fence_ok)
  );

  mo_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .req   (legal),
    .head  (head),
    .found (found),
    .idx   (pick)
  );

  assign iss_valid = found;
  assign iss_kind  = slots[pick].kind;
  assign iss_tag   = tags[pick];

endmodule

// File: rtl/mo_issue_gate_chk.sv
module mo_issue_gate_chk
  import mo_gate_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input model_e            model_q,
  input logic [CNT_W-1:0]  count,
  input logic              in_ready,
  input logic              iss_valid,
  input logic [1:0]        iss_kind,
  input slot_t [DEPTH-1:0] slots
);

  logic outstanding;
  always_comb begin
    outstanding = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (slots[i].vld && slots[i].issued && !slots[i].done) outstanding = 1'b1;
  end

  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !iss_valid);

  p_seq_one_at_a_time_r2: assert property (@(posedge clk) disable iff (rst)
    (model_q == M_SEQ && iss_valid) |-> !outstanding);

  p_fence_stays_inside_r6: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (iss_kind != 2'd2));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !in_ready);

  p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_model_held_r12: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> $stable(model_q));

endmodule

bind mo_issue_gate mo_issue_gate_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .model_q   (model_q),
  .count     (count),
  .in_ready  (in_ready),
  .iss_valid (iss_valid),
  .iss_kind  (iss_kind),
  .slots     (slots)
);

// File: tb/mo_issue_gate_test.sv
module mo_issue_gate_test;

  localparam int TAG_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       model_sel = 2'd0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       in_kind = 2'd0;
  logic [1:0]       in_fence = 2'd0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             iss_valid;
  logic             iss_ready = 1'b0;
  logic [1:0]       iss_kind;
  logic [TAG_W-1:0] iss_tag;
  logic             ack_valid = 1'b0;
  logic [TAG_W-1:0] ack_tag = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mo_issue_gate #(.DEPTH(8), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst(rst), .model_sel(model_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_fence(in_fence), .in_tag(in_tag),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_kind(iss_kind),
    .iss_tag(iss_tag), .ack_valid(ack_valid), .ack_tag(ack_tag)
  );

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FN = 2'd2, AM = 2'd3;
  localparam logic [1:0] F_ALL = 2'd0, F_LD = 2'd1, F_ST = 2'd2;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enq(logic [1:0] k, logic [1:0] f, int t);
    in_valid = 1'b1; in_kind = k; in_fence = f; in_tag = TAG_W'(t);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take(int t, string req);
    chk({req, " iss_valid"}, int'(iss_valid), 1);
    chk({req, " iss_tag"}, int'(iss_tag), t);
    iss_ready = 1'b1;
    @(negedge clk);
    iss_ready = 1'b0;
  endtask

  task automatic none(string req);
    chk({req, " held back"}, int'(iss_valid), 0);
  endtask

  task automatic ack(int t);
    ack_valid = 1'b1; ack_tag = TAG_W'(t);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_all();
    for (int t = 0; t < 8; t++) ack(t);
  endtask

  task automatic flush();
    bit pend = 0;
    logic [TAG_W-1:0] ptag = '0;
    ack_all();
    for (int c = 0; c < 30; c++) begin
      bit nv;
      logic [TAG_W-1:0] nt;
      iss_ready = 1'b1;
      ack_valid = pend;
      ack_tag = ptag;
      nv = iss_valid;
      nt = iss_tag;
      @(negedge clk);
      pend = nv;
      ptag = nt;
    end
    iss_ready = 1'b0;
    ack_valid = 1'b0;
    ack_all();
    idle(2);
  endtask

  task automatic set_model(logic [1:0] m);
    model_sel = m;
    idle(2);
  endtask

  task automatic t_reset();
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 iss_valid", int'(iss_valid), 0);
  endtask

  task automatic t_seq();
    set_model(2'd0);
    enq(ST, F_ALL, 1); enq(LD, F_ALL, 2);
    take(1, "R2");
    idle(2);
    none("R2 load behind store");
    ack(1);
    take(2, "R2");
    flush();
  endtask

  task automatic t_tso();
    set_model(2'd1);
    enq(ST, F_ALL, 1); enq(ST, F_ALL, 2); enq(LD, F_ALL, 3);
    take(1, "R3");
    take(3, "R3 load passes store");
    none("R3 store behind store");
    ack(1);
    take(2, "R3");
    flush();
  endtask

  task automatic t_pso();
    set_model(2'd2);
    enq(LD, F_ALL, 1); enq(ST, F_ALL, 2); enq(LD, F_ALL, 3);
    take(1, "R4");
    none("R4 nothing passes load");
    ack(1);
    take(2, "R10 oldest first");
    take(3, "R4 load passes store");
    flush();
    enq(ST, F_ALL, 4); enq(ST, F_ALL, 5);
    take(4, "R4");
    take(5, "R4 store passes store");
    flush();
  endtask

  task automatic t_weak();
    set_model(2'd3);
    enq(LD, F_ALL, 1); enq(LD, F_ALL, 2); enq(ST, F_ALL, 3);
    take(1, "R5");
    take(2, "R5 load passes load");
    take(3, "R5 store passes load");
    flush();
  endtask

  task automatic t_full_fence();
    enq(ST, F_ALL, 1);
    take(1, "R6");
    enq(FN, F_ALL, 6); enq(LD, F_ALL, 2);
    idle(2);
    none("R6 fence blocks");
    ack(1);
    idle(2);
    take(2, "R6 after fence, fence not issued");
    flush();
  endtask

  task automatic t_load_fence();
    enq(LD, F_ALL, 1);
    take(1, "R7");
    enq(FN, F_LD, 6); enq(ST, F_ALL, 2); enq(LD, F_ALL, 3);
    take(2, "R7 store passes load fence");
    none("R7 load blocked");
    ack(1);
    idle(2);
    take(3, "R7");
    flush();
  endtask

  task automatic t_store_fence();
    enq(ST, F_ALL, 1);
    take(1, "R8");
    enq(FN, F_ST, 6); enq(LD, F_ALL, 2); enq(ST, F_ALL, 3);
    take(2, "R8 load passes store fence");
    none("R8 store blocked");
    ack(1);
    idle(2);
    take(3, "R8");
    flush();
  endtask

  task automatic t_atomic();
    enq(LD, F_ALL, 1);
    take(1, "R9");
    enq(AM, F_ALL, 2); enq(LD, F_ALL, 3);
    idle(1);
    none("R9 atomic waits older");
    ack(1);
    idle(1);
    chk("R9 iss_kind atomic", int'(iss_kind), 3);
    take(2, "R9");
    none("R9 younger waits atomic");
    ack(2);
    idle(1);
    take(3, "R9");
    flush();
  endtask

  task automatic t_full();
    for (int t = 0; t < 8; t++) enq(LD, F_ALL, t);
    chk("R11 in_ready full", int'(in_ready), 0);
    for (int t = 0; t < 8; t++) take(t, "R10 order");
    ack(3);
    idle(2);
    chk("R11 young ack frees nothing", int'(in_ready), 0);
    ack(0);
    idle(1);
    chk("R11 head retire frees", int'(in_ready), 1);
    ack_all();
    flush();
  endtask

  task automatic t_model_change();
    set_model(2'd0);
    enq(ST, F_ALL, 1);
    take(1, "R12");
    model_sel = 2'd3;
    enq(LD, F_ALL, 2);
    idle(2);
    none("R12 change ignored while busy");
    ack(1);
    take(2, "R12");
    ack(2);
    idle(2);
    enq(ST, F_ALL, 3);
    take(3, "R12");
    enq(ST, F_ALL, 4);
    take(4, "R12 new model applied");
    flush();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_seq();
    t_tso();
    t_pso();
    t_weak();
    t_full_fence();
    t_load_fence();
    t_store_fence();
    t_atomic();
    t_full();
    t_model_change();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule